// File: doc/BRIEF.md
# Ethernet Length/Type Frame Classifier

This block watches a received Ethernet frame that arrives one byte per beat. The stream runs from the first destination-address byte through the last FCS byte. Three strobes frame it: a valid, a start-of-frame and an end-of-frame. The block locates the two-byte length/type word and steps over up to two stacked VLAN tags. It then sorts the frame into exactly one class and checks its lengths. For MAC control frames it also decodes the opcode.

A single result set appears for one cycle, right after the end-of-frame beat. It holds a one-hot class, the number of VLAN tags skipped, a payload-length error, a frame-size error and the pause and PFC indications. Downstream logic uses this result to drop, count or act on the frame. The parser is ready for the next start-of-frame on the very next beat.

Top module: `eth_lt_classifier`

## Requirements
- R1: The result class is one-hot on `res_class`. Bit 0 is length frame, bit 1 is non-standard, bit 2 is MAC control, bit 3 is client and bit 4 is truncated. A length/type value of 1500 (0x05DC) or less gives bit 0.
- R2: A length/type value from 1501 to 1535 gives bit 1, and such a frame never raises `res_len_err`.
- R3: A value of 1536 (0x0600) or more gives bit 3 and no payload check. The exceptions are 0x8808, and 0x8100 while tags can still be taken. A third 0x8100 is an ordinary client type.
- R4: A 0x8100 word is a VLAN tag. The two bytes after it are skipped, and the next two bytes are read as the new length/type. At most two tags are followed, and `res_tags` reports how many were taken.
- R5: Type 0x8808 gives bit 2. Opcode 0x0001 in the next two bytes raises `res_pause`, and opcode 0x0101 raises `res_pfc`. Any other opcode raises neither, and neither is raised outside class bit 2.
- R6: For a length frame, `res_len_err` is set when the declared length exceeds the received payload. The payload is the total bytes less 14 header bytes, 4 bytes per tag and 4 FCS bytes. A declared length at or below the payload (padding) is not an error.
- R7: `res_size_err` is set when the total frame length is below 64 or above 1518 + 4 × tags. This applies to every class.
- R8: A frame that ends before its length/type word is complete gives bit 4 and `res_size_err`.
- R9: `res_valid` is high for exactly the one cycle after an end-of-frame beat. All other result outputs are zero whenever `res_valid` is low. Frames may follow each other with no idle beat.
- R10: Beats with `in_valid` low are ignored. Beats outside a frame that lack a start-of-frame are ignored. A start-of-frame in the middle of a frame abandons the old frame and starts parsing afresh.
- R11: During and right after reset, `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame (final FCS byte) |
| in_data | input | 8 | Frame byte |
| res_valid | output | 1 | Result strobe, one cycle |
| res_class | output | 5 | One-hot frame class |
| res_tags | output | 2 | VLAN tags skipped |
| res_len_err | output | 1 | Declared length larger than payload |
| res_size_err | output | 1 | Total length outside allowed range |
| res_pause | output | 1 | Pause opcode seen |
| res_pfc | output | 1 | Priority flow control opcode seen |

## Verification
The checker assumes that reset is applied before the first frame. It also takes it that an end-of-frame beat can only produce a result when it closes a frame that was opened by a start-of-frame, so its timing property only checks that every result was preceded by a valid end-of-frame beat. The directed stimulus always asserts reset first. Where it drives stray end-of-frame beats with no open frame, it confirms at the ports that no result follows. Idle beats inserted inside frames carry misleading strobe values with `in_valid` low, which exercises the rule that unqualified beats have no effect.

// File: rtl/eth_lt_pkg.sv
package eth_lt_pkg;

    localparam int CLS_W     = 5;
    localparam int CL_LEN    = 0;
    localparam int CL_NONSTD = 1;
    localparam int CL_CTRL   = 2;
    localparam int CL_CLIENT = 3;
    localparam int CL_TRUNC  = 4;

    localparam logic [15:0] LEN_MAX_VAL   = 16'h05DC;
    localparam logic [15:0] TYPE_MIN_VAL  = 16'h0600;
    localparam logic [15:0] TPID_VLAN     = 16'h8100;
    localparam logic [15:0] TYPE_MAC_CTL  = 16'h8808;
    localparam logic [15:0] OPC_PAUSE     = 16'h0001;
    localparam logic [15:0] OPC_PFC       = 16'h0101;

    localparam int HDR_BYTES   = 14;
    localparam int FCS_BYTES   = 4;
    localparam int TYPE_OFFSET = 12;

    localparam int DEF_CNT_W     = 16;
    localparam int DEF_MAX_TAGS  = 2;
    localparam int DEF_TAG_BYTES = 4;
    localparam int DEF_MIN_FRAME = 64;
    localparam int DEF_MAX_FRAME = 1518;

    // Fields captured by the parser for one frame
    typedef struct packed {
        logic [15:0] lt;
        logic        lt_done;
        logic [15:0] op;
        logic        op_done;
    } fields_t;

    // Registered result of one frame
    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic             len_err;
        logic             size_err;
        logic             pause;
        logic             pfc;
    } result_t;

    function automatic logic [CLS_W-1:0] cls_bit(input int idx);
        logic [CLS_W-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/eth_lt_parser.sv
module eth_lt_parser
    import eth_lt_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int MAX_TAGS  = DEF_MAX_TAGS,
    parameter int TAG_BYTES = DEF_TAG_BYTES,
    localparam int TAG_W    = $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             frame_end,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [TAG_W-1:0] nxt_tags,
    output fields_t          nxt_fields
);

    logic             in_frame_q;
    logic             start, beat;
    logic [CNT_W-1:0] cnt_q, cnt_b, cnt_d;
    logic [CNT_W-1:0] tpos_q, tpos_b, tpos_d;
    logic [TAG_W-1:0] tags_q, tags_b, tags_d;
    logic [7:0]       hi_q, hi_b, hi_d;
    fields_t          fld_q, fld_b, fld_d;
    logic [15:0]      word;

    assign start = in_valid && in_sof;
    assign beat  = in_valid && (in_sof || in_frame_q);

    always_comb begin
        if (start) begin
            cnt_b  = '0;
            tpos_b = CNT_W'(TYPE_OFFSET);
            tags_b = '0;
            hi_b   = '0;
            fld_b  = '0;
        end else begin
            cnt_b  = cnt_q;
            tpos_b = tpos_q;
            tags_b = tags_q;
            hi_b   = hi_q;
            fld_b  = fld_q;
        end

        cnt_d  = cnt_b;
        tpos_d = tpos_b;
        tags_d = tags_b;
        hi_d   = hi_b;
        fld_d  = fld_b;
        word   = {hi_b, in_data};

        if (beat) begin
            if (!fld_b.lt_done) begin
                if (cnt_b == tpos_b) begin
                    hi_d = in_data;
                end else if (cnt_b == tpos_b + CNT_W'(1)) begin
                    if (word == TPID_VLAN && tags_b < TAG_W'(MAX_TAGS)) begin
                        tags_d = tags_b + TAG_W'(1);
                        tpos_d = tpos_b + CNT_W'(TAG_BYTES);
                    end else begin
                        fld_d.lt      = word;
                        fld_d.lt_done = 1'b1;
                    end
                end
            end else if (!fld_b.op_done) begin
                if (cnt_b == tpos_b + CNT_W'(2)) begin
                    fld_d.op[15:8] = in_data;
                end else if (cnt_b == tpos_b + CNT_W'(3)) begin
                    fld_d.op[7:0] = in_data;
                    fld_d.op_done = 1'b1;
                end
            end
            if (cnt_b != '1) begin
                cnt_d = cnt_b + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
            tpos_q     <= CNT_W'(TYPE_OFFSET);
            tags_q     <= '0;
            hi_q       <= '0;
            fld_q      <= '0;
        end else begin
            if (beat) begin
                in_frame_q <= !in_eof;
            end
            cnt_q  <= cnt_d;
            tpos_q <= tpos_d;
            tags_q <= tags_d;
            hi_q   <= hi_d;
            fld_q  <= fld_d;
        end
    end

    assign frame_end  = beat && in_eof;
    assign nxt_cnt    = cnt_d;
    assign nxt_tags   = tags_d;
    assign nxt_fields = fld_d;

endmodule

// File: rtl/eth_lt_typedec.sv
module eth_lt_typedec
    import eth_lt_pkg::*;
(
    input  fields_t          fld,
    output logic [CLS_W-1:0] cls,
    output logic             pause,
    output logic             pfc
);

    always_comb begin
        if (!fld.lt_done) begin
            cls = cls_bit(CL_TRUNC);
        end else if (fld.lt <= LEN_MAX_VAL) begin
            cls = cls_bit(CL_LEN);
        end else if (fld.lt < TYPE_MIN_VAL) begin
            cls = cls_bit(CL_NONSTD);
        end else if (fld.lt == TYPE_MAC_CTL) begin
            cls = cls_bit(CL_CTRL);
        end else begin
            cls = cls_bit(CL_CLIENT);
        end
        pause = cls[CL_CTRL] && fld.op_done && (fld.op == OPC_PAUSE);
        pfc   = cls[CL_CTRL] && fld.op_done && (fld.op == OPC_PFC);
    end

endmodule

// File: rtl/eth_lt_lencheck.sv
module eth_lt_lencheck
    import eth_lt_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int TAG_W     = 2,
    parameter int TAG_BYTES = DEF_TAG_BYTES,
    parameter int MIN_FRAME = DEF_MIN_FRAME,
    parameter int MAX_FRAME = DEF_MAX_FRAME
) (
    input  logic [CNT_W-1:0] total,
    input  logic [TAG_W-1:0] tags,
    input  logic [15:0]      lt,
    input  logic             chk_payload,
    output logic             len_err,
    output logic             size_err
);

    localparam int SUM_W = ((CNT_W > 16) ? CNT_W : 16) + 3;

    logic [SUM_W-1:0] tag_bytes, need, tot, upper;

    always_comb begin
        tag_bytes = SUM_W'(tags) * SUM_W'(TAG_BYTES);
        need      = SUM_W'(lt) + SUM_W'(HDR_BYTES + FCS_BYTES) + tag_bytes;
        tot       = SUM_W'(total);
        upper     = SUM_W'(MAX_FRAME) + tag_bytes;
        len_err   = chk_payload && (need > tot);
        size_err  = (tot < SUM_W'(MIN_FRAME)) || (tot > upper);
    end

endmodule

// File: rtl/eth_lt_classifier.sv
module eth_lt_classifier
    import eth_lt_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int MAX_TAGS  = DEF_MAX_TAGS,
    parameter int TAG_BYTES = DEF_TAG_BYTES,
    parameter int MIN_FRAME = DEF_MIN_FRAME,
    parameter int MAX_FRAME = DEF_MAX_FRAME,
    localparam int TAG_W    = $clog2(MAX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             res_valid,
    output logic [CLS_W-1:0] res_class,
    output logic [TAG_W-1:0] res_tags,
    output logic             res_len_err,
    output logic             res_size_err,
    output logic             res_pause,
    output logic             res_pfc
);

    logic             frame_end;
    logic [CNT_W-1:0] nxt_cnt;
    logic [TAG_W-1:0] nxt_tags;
    fields_t          nxt_fields;
    result_t          res_d, res_q;
    logic [TAG_W-1:0] tags_q;

    eth_lt_parser #(
        .CNT_W     (CNT_W),
        .MAX_TAGS  (MAX_TAGS),
        .TAG_BYTES (TAG_BYTES)
    ) u_parser (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_data    (in_data),
        .frame_end  (frame_end),
        .nxt_cnt    (nxt_cnt),
        .nxt_tags   (nxt_tags),
        .nxt_fields (nxt_fields)
    );

    eth_lt_typedec u_typedec (
        .fld   (nxt_fields),
        .cls   (res_d.cls),
        .pause (res_d.pause),
        .pfc   (res_d.pfc)
    );

    eth_lt_lencheck #(
        .CNT_W     (CNT_W),
        .TAG_W     (TAG_W),
        .TAG_BYTES (TAG_BYTES),
        .MIN_FRAME (MIN_FRAME),
        .MAX_FRAME (MAX_FRAME)
    ) u_lencheck (
        .total       (nxt_cnt),
        .tags        (nxt_tags),
        .lt          (nxt_fields.lt),
        .chk_payload (res_d.cls[CL_LEN]),
        .len_err     (res_d.len_err),
        .size_err    (res_d.size_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '0;
            tags_q    <= '0;
        end else begin
            res_valid <= frame_end;
            if (frame_end) begin
                res_q  <= res_d;
                tags_q <= nxt_tags;
            end else begin
                res_q  <= '0;
                tags_q <= '0;
            end
        end
    end

    assign res_class    = res_q.cls;
    assign res_tags     = tags_q;
    assign res_len_err  = res_q.len_err;
    assign res_size_err = res_q.size_err;
    assign res_pause    = res_q.pause;
    assign res_pfc      = res_q.pfc;

endmodule

// File: rtl/eth_lt_classifier_chk.sv
module eth_lt_classifier_chk
    import eth_lt_pkg::*;
#(
    parameter int MAX_TAGS = DEF_MAX_TAGS,
    parameter int TAG_W    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_eof,
    input logic             res_valid,
    input logic [CLS_W-1:0] res_class,
    input logic [TAG_W-1:0] res_tags,
    input logic             res_len_err,
    input logic             res_size_err,
    input logic             res_pause,
    input logic             res_pfc
);

    // R9
    valid_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_eof));

    // R1
    class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones(res_class) == 1));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_class == '0 && res_tags == '0 && !res_len_err
                        && !res_size_err && !res_pause && !res_pfc));

    // R6
    len_err_scope_chk: assert property (@(posedge clk) disable iff (rst)
        res_len_err |-> res_class[CL_LEN]);

    // R5
    ctrl_ind_chk: assert property (@(posedge clk) disable iff (rst)
        (res_pause || res_pfc) |-> (res_class[CL_CTRL] && !(res_pause && res_pfc)));

    // R4
    tag_bound_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_tags <= TAG_W'(MAX_TAGS)));

    // R8
    trunc_size_chk: assert property (@(posedge clk) disable iff (rst)
        res_class[CL_TRUNC] |-> res_size_err);

endmodule

bind eth_lt_classifier eth_lt_classifier_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_eof       (in_eof),
    .res_valid    (res_valid),
    .res_class    (res_class),
    .res_tags     (res_tags),
    .res_len_err  (res_len_err),
    .res_size_err (res_size_err),
    .res_pause    (res_pause),
    .res_pfc      (res_pfc)
);

// File: tb/eth_lt_classifier_tb.sv
`timescale 1ns/1ps
module eth_lt_classifier_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       res_valid, res_len_err, res_size_err, res_pause, res_pfc;
    logic [4:0] res_class;
    logic [1:0] res_tags;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] fr [0:2047];
    logic       cap_valid, cap_pause;
    logic [4:0] cap_class;

    localparam logic [4:0] C_LEN = 5'b00001, C_NST = 5'b00010, C_CTL = 5'b00100,
                           C_CLI = 5'b01000, C_TRN = 5'b10000;

    always #2 clk = ~clk;

    eth_lt_classifier u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .res_valid(res_valid), .res_class(res_class), .res_tags(res_tags),
        .res_len_err(res_len_err), .res_size_err(res_size_err), .res_pause(res_pause),
        .res_pfc(res_pfc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build(input int n);
        for (int i = 0; i < 2048; i++) fr[i] = 8'(i * 7 + 3);
    endtask

    task automatic put16(input int pos, input logic [15:0] v);
        fr[pos]     = v[15:8];
        fr[pos + 1] = v[7:0];
    endtask

    task automatic drive_bytes(input int n, input bit gap, input bit do_eof);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h81;
            end
            @(negedge clk);
            if (i == 0) begin
                cap_valid = res_valid; cap_class = res_class; cap_pause = res_pause;
            end
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = do_eof && (i == n - 1);
            in_data  = fr[i];
        end
    endtask

    task automatic expect_res(input string req, input logic [4:0] cls, input int tags,
                              input bit le, input bit se, input bit pa, input bit pf);
        @(negedge clk);
        chk(req, "valid", res_valid, 1);
        chk(req, "class", res_class, cls);
        chk(req, "tags", res_tags, tags);
        chk(req, "len_err", res_len_err, le);
        chk(req, "size_err", res_size_err, se);
        chk(req, "pause", res_pause, pa);
        chk(req, "pfc", res_pfc, pf);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        chk("R9", "valid one cycle", res_valid, 0);
        chk("R9", "class cleared", res_class, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R11", "valid in reset", res_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "valid after reset", res_valid, 0);
        chk("R11", "class after reset", res_class, 0);
    endtask

    task automatic t_length;
        build(64); put16(12, 16'd46); drive_bytes(64, 0, 1);
        expect_res("R1", C_LEN, 0, 0, 0, 0, 0);
        build(64); put16(12, 16'd10); drive_bytes(64, 0, 1);
        expect_res("R6 padding", C_LEN, 0, 0, 0, 0, 0);
        build(64); put16(12, 16'd100); drive_bytes(64, 0, 1);
        expect_res("R6 short payload", C_LEN, 0, 1, 0, 0, 0);
        build(1518); put16(12, 16'd1500); drive_bytes(1518, 0, 1);
        expect_res("R7 max", C_LEN, 0, 0, 0, 0, 0);
        build(1519); put16(12, 16'd1500); drive_bytes(1519, 0, 1);
        expect_res("R7 over", C_LEN, 0, 0, 1, 0, 0);
        build(63); put16(12, 16'd45); drive_bytes(63, 0, 1);
        expect_res("R7 under", C_LEN, 0, 0, 1, 0, 0);
    endtask

    task automatic t_types;
        build(64); put16(12, 16'd1501); drive_bytes(64, 0, 1);
        expect_res("R2 1501", C_NST, 0, 0, 0, 0, 0);
        build(64); put16(12, 16'd1535); drive_bytes(64, 0, 1);
        expect_res("R2 1535", C_NST, 0, 0, 0, 0, 0);
        build(64); put16(12, 16'd1536); drive_bytes(64, 0, 1);
        expect_res("R3 1536", C_CLI, 0, 0, 0, 0, 0);
        build(100); put16(12, 16'h0800); drive_bytes(100, 0, 1);
        expect_res("R3 ipv4", C_CLI, 0, 0, 0, 0, 0);
    endtask

    task automatic t_vlan;
        build(72); put16(12, 16'h8100); put16(14, 16'h8100); put16(16, 16'd50);
        drive_bytes(72, 0, 1);
        expect_res("R4 one tag", C_LEN, 1, 0, 0, 0, 0);
        build(72); put16(12, 16'h8100); put16(16, 16'd51); drive_bytes(72, 0, 1);
        expect_res("R6 tagged", C_LEN, 1, 1, 0, 0, 0);
        build(1522); put16(12, 16'h8100); put16(16, 16'h0800); drive_bytes(1522, 0, 1);
        expect_res("R7 one tag max", C_CLI, 1, 0, 0, 0, 0);
        build(1523); put16(12, 16'h8100); put16(16, 16'h0800); drive_bytes(1523, 0, 1);
        expect_res("R7 one tag over", C_CLI, 1, 0, 1, 0, 0);
        build(1526); put16(12, 16'h8100); put16(16, 16'h8100); put16(20, 16'h0800);
        drive_bytes(1526, 0, 1);
        expect_res("R4 two tags", C_CLI, 2, 0, 0, 0, 0);
        build(1527); put16(12, 16'h8100); put16(16, 16'h8100); put16(20, 16'h0800);
        drive_bytes(1527, 0, 1);
        expect_res("R7 two tags over", C_CLI, 2, 0, 1, 0, 0);
        build(64); put16(12, 16'h8100); put16(16, 16'h8100); put16(20, 16'h8100);
        drive_bytes(64, 0, 1);
        expect_res("R3 third tag", C_CLI, 2, 0, 0, 0, 0);
    endtask

    task automatic t_ctrl;
        build(64); put16(12, 16'h8808); put16(14, 16'h0001); drive_bytes(64, 0, 1);
        expect_res("R5 pause", C_CTL, 0, 0, 0, 1, 0);
        build(64); put16(12, 16'h8808); put16(14, 16'h0101); drive_bytes(64, 0, 1);
        expect_res("R5 pfc", C_CTL, 0, 0, 0, 0, 1);
        build(64); put16(12, 16'h8808); put16(14, 16'h0002); drive_bytes(64, 0, 1);
        expect_res("R5 other op", C_CTL, 0, 0, 0, 0, 0);
        build(68); put16(12, 16'h8100); put16(16, 16'h8808); put16(18, 16'h0001);
        drive_bytes(68, 0, 1);
        expect_res("R5 tagged pause", C_CTL, 1, 0, 0, 1, 0);
        build(64); put16(12, 16'h0800); put16(14, 16'h0001); drive_bytes(64, 0, 1);
        expect_res("R5 non-ctrl op", C_CLI, 0, 0, 0, 0, 0);
    endtask

    task automatic t_trunc;
        build(13); drive_bytes(13, 0, 1);
        expect_res("R8 13 bytes", C_TRN, 0, 0, 1, 0, 0);
        build(1); drive_bytes(1, 0, 1);
        expect_res("R8 single beat", C_TRN, 0, 0, 1, 0, 0);
        build(14); put16(12, 16'h0800); drive_bytes(14, 0, 1);
        expect_res("R8 type on eof", C_CLI, 0, 0, 1, 0, 0);
    endtask

    task automatic t_ignore;
        build(64); put16(12, 16'd46); drive_bytes(64, 1, 1);
        expect_res("R10 gaps", C_LEN, 0, 0, 0, 0, 0);
        build(64); put16(12, 16'h8808); put16(14, 16'h0001); drive_bytes(20, 0, 0);
        build(64); put16(12, 16'd46); drive_bytes(64, 0, 1);
        chk("R10", "restart no early result", cap_valid, 0);
        expect_res("R10 restart", C_LEN, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 8'h55;
        end
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        chk("R10", "stray eof ignored", res_valid, 0);
        @(negedge clk);
        chk("R10", "stray eof ignored later", res_valid, 0);
    endtask

    task automatic t_back_to_back;
        build(64); put16(12, 16'h8808); put16(14, 16'h0001); drive_bytes(64, 0, 1);
        build(64); put16(12, 16'd46); drive_bytes(64, 0, 1);
        chk("R9", "first result valid", cap_valid, 1);
        chk("R9", "first result class", cap_class, C_CTL);
        chk("R9", "first result pause", cap_pause, 1);
        expect_res("R9 second", C_LEN, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_length();
        t_types();
        t_vlan();
        t_ctrl();
        t_trunc();
        t_ignore();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule